// File: doc/BRIEF.md
# UART Auto-Baud Synchroniser

This block listens on an idle-high serial receive line for one synchronisation character, 0x7F. The character is sent as 8E1: a start bit, eight data bits LSB first, an even parity bit and a stop bit. A counter clocked by the system clock times the character, and from that count the block works out how many system clocks make up one bit. When the count is accepted, the block registers that number as the baud divisor and raises a lock flag. It then sends the acknowledge byte 0x79 on its transmit line in the same 8E1 format at the rate it just measured.

On the line, 0x7F goes low for the start bit, high for data bits 0 to 6, low for data bit 7, and high for parity (seven ones, so the parity bit is 1) and stop. The measurement runs from the falling edge that opens the start bit to the second rising edge that follows it, which closes data bit 7. That span is exactly nine bit times. A count that falls outside a configured window is thrown away, and the detector waits for a new falling edge. Lock is sticky until reset. Once a measurement is accepted, the block ignores any further activity on the receive line.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, locked_o is 0, div_o is 0, busy_o is 0 and tx_o is 1.
- R2: Let T be the number of system clocks between the start-bit falling edge and the second rising edge after it. If T is accepted, div_o becomes round(T/9), computed as floor((T+4)/9), and locked_o rises.
- R3: A measurement with T below MIN_CNT is discarded and the block does not lock. The next valid sync character on the line still locks. T equal to MIN_CNT is accepted.
- R4: A measurement with T above MAX_CNT is discarded. This includes a line held low for longer than MAX_CNT. The block rearms and does not lock. T equal to MAX_CNT is accepted.
- R5: After lock, tx_o sends one 8E1 frame carrying 0x79. The frame is a start bit of 0, the data bits LSB first (1,0,0,1,1,1,1,0), a parity bit of 1 and a stop bit of 1. Each bit lasts div_o clocks.
- R6: busy_o is 1 while a measurement is in progress and from lock until the end of the acknowledge stop bit. It is 0 when idle and after a discarded measurement.
- R7: Once locked, edges on rx_i have no effect. locked_o and div_o hold, the acknowledge frame is unaltered, and no second frame is sent.
- R8: tx_o is 1 whenever no acknowledge frame is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| div_o | output | CNT_W | Measured bit period in system clocks |
| locked_o | output | 1 | Divisor valid, sticky until reset |
| tx_o | output | 1 | Serial transmit line carrying the acknowledge |
| busy_o | output | 1 | Measurement or acknowledge in progress |

## Verification
If the edge-sequencing state goes wrong, the block locks on the wrong edge or fails to lock. That appears on div_o within three clocks of the closing rising edge, as a divisor that differs from round(T/9). If the window comparison goes wrong, a rejected boundary count leads to a lock and an acknowledge frame, or an accepted one leaves locked_o low. If the serialiser goes wrong, it shows within one bit period: the start bit has the wrong length, or the decoded byte, parity bit or stop bit differs. If the post-lock guard goes wrong, a second sync changes div_o or starts a new low pulse on tx_o.

// File: rtl/abr_pkg.sv
package abr_pkg;

  localparam int SYNC_BIT_TIMES = 9;
  localparam int FRAME_BITS     = 11;
  localparam logic [7:0] ACK_BYTE = 8'h79;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_LOW1,
    MS_HIGH1,
    MS_LOW2,
    MS_LOCKED
  } meas_st_e;

  // 8 data bits, even parity, one stop bit; bit 0 goes on the line first.
  function automatic logic [FRAME_BITS-1:0] frame_8e1(input logic [7:0] d);
    return {1'b1, ^d, d, 1'b0};
  endfunction

endpackage

// File: rtl/abr_edge.sv
module abr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx,
  output logic fall,
  output logic rise
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-1:0], rx};
  end

  assign fall = sr[STAGES] & ~sr[STAGES-1];
  assign rise = ~sr[STAGES] & sr[STAGES-1];
endmodule

// File: rtl/abr_measure.sv
module abr_measure
  import abr_pkg::*;
#(
  parameter int MIN_CNT = 36,
  parameter int MAX_CNT = 1800,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             rise,
  output logic [CNT_W-1:0] div_o,
  output logic             locked_o,
  output logic             go_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_CNT);
  localparam logic [CNT_W-1:0] CNT_LOW = CNT_W'(MIN_CNT - 1);
  localparam logic [CNT_W-1:0] DIV_FLOOR = CNT_W'((MIN_CNT + SYNC_BIT_TIMES/2) / SYNC_BIT_TIMES);

  meas_st_e         state;
  logic [CNT_W-1:0] cnt;

  // cnt holds T-1 when the closing edge arrives; rounding of T/9 to nearest.
  function automatic logic [CNT_W-1:0] round_div(input logic [CNT_W-1:0] c);
    logic [CNT_W:0] w;
    w = ({1'b0, c} + (CNT_W+1)'(SYNC_BIT_TIMES/2 + 1)) / (CNT_W+1)'(SYNC_BIT_TIMES);
    return CNT_W'(w);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MS_IDLE;
      cnt      <= '0;
      div_o    <= '0;
      locked_o <= 1'b0;
      go_o     <= 1'b0;
    end else begin
      go_o <= 1'b0;
      case (state)
        MS_IDLE: begin
          if (fall) begin
            cnt   <= '0;
            state <= MS_LOW1;
          end
        end
        MS_LOW1, MS_HIGH1, MS_LOW2: begin
          if (cnt >= CNT_CAP) begin
            state <= MS_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
            if (state == MS_LOW1 && rise)       state <= MS_HIGH1;
            else if (state == MS_HIGH1 && fall) state <= MS_LOW2;
            else if (state == MS_LOW2 && rise) begin
              if (cnt >= CNT_LOW) begin
                div_o    <= round_div(cnt);
                locked_o <= 1'b1;
                go_o     <= 1'b1;
                state    <= MS_LOCKED;
              end else begin
                state <= MS_IDLE;
              end
            end
          end
        end
        MS_LOCKED: state <= MS_LOCKED;
        default:   state <= MS_IDLE;
      endcase
    end
  end

  assign active_o = (state == MS_LOW1) || (state == MS_HIGH1) || (state == MS_LOW2);

  a_r4_count_capped: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (cnt <= CNT_CAP));
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> (locked_o && $stable(div_o)));
  a_r3_div_floor: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> (div_o >= DIV_FLOOR));
  a_r2_single_go: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o);
endmodule

// File: rtl/abr_tx.sv
module abr_tx
  import abr_pkg::*;
#(
  parameter int         CNT_W = 11,
  parameter logic [7:0] DATA  = ACK_BYTE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] div,
  output logic             tx_o,
  output logic             busy_o
);
  localparam int LEFT_W = $clog2(FRAME_BITS);
  localparam logic [FRAME_BITS-1:0] FRAME = frame_8e1(DATA);

  logic [FRAME_BITS-2:0] shreg;
  logic [LEFT_W-1:0]     left;
  logic [CNT_W-1:0]      baud;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_o   <= 1'b1;
      busy_o <= 1'b0;
      shreg  <= '0;
      left   <= '0;
      baud   <= '0;
    end else if (!busy_o) begin
      if (start) begin
        tx_o   <= FRAME[0];
        shreg  <= FRAME[FRAME_BITS-1:1];
        left   <= LEFT_W'(FRAME_BITS - 1);
        baud   <= '0;
        busy_o <= 1'b1;
      end
    end else if (baud == div - CNT_W'(1)) begin
      baud <= '0;
      if (left == '0) begin
        busy_o <= 1'b0;
      end else begin
        tx_o  <= shreg[0];
        shreg <= shreg >> 1;
        left  <= left - LEFT_W'(1);
      end
    end else begin
      baud <= baud + CNT_W'(1);
    end
  end

  a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> tx_o);
  a_r5_baud_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (baud < div));
  a_r5_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !tx_o);
endmodule

// File: rtl/autobaud_sync.sv
module autobaud_sync #(
  parameter int MIN_CNT     = 36,
  parameter int MAX_CNT     = 9 * 4096,
  parameter int CNT_W       = $clog2(MAX_CNT + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  output logic [CNT_W-1:0] div_o,
  output logic             locked_o,
  output logic             tx_o,
  output logic             busy_o
);
  logic fall, rise, go, active, tx_busy;

  abr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .rx(rx_i), .fall(fall), .rise(rise)
  );

  abr_measure #(.MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT), .CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .div_o(div_o), .locked_o(locked_o), .go_o(go), .active_o(active)
  );

  abr_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .start(go), .div(div_o),
    .tx_o(tx_o), .busy_o(tx_busy)
  );

  assign busy_o = active | go | tx_busy;

  a_r6_busy_at_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> busy_o);
endmodule

// File: tb/tb_autobaud_sync.sv
module tb_autobaud_sync;
  localparam int MIN_C = 36;
  localparam int MAX_C = 1800;
  localparam int CW    = $clog2(MAX_C + 1);

  logic clk = 0, rst = 1, rx = 1;
  logic [CW-1:0] div;
  logic locked, tx, busy;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  autobaud_sync #(.MIN_CNT(MIN_C), .MAX_CNT(MAX_C)) dut (
    .clk(clk), .rst(rst), .rx_i(rx), .div_o(div),
    .locked_o(locked), .tx_o(tx), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_div(input int t);
    return (t + 4) / 9;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  task automatic do_reset();
    rst = 1; rx = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  // Sync character of total measured span t clocks (fall to closing rise).
  task automatic send_sync(input int t, input bit exp_busy);
    int b = t / 9;
    int r = t % 9;
    rx = 0; repeat (b) @(negedge clk);
    rx = 1; repeat (7 * b) @(negedge clk);
    chk(busy == exp_busy, "R6", "busy during sync", busy, exp_busy);
    rx = 0; repeat (b + r) @(negedge clk);
    rx = 1;
  endtask

  task automatic check_ack(input int d);
    int waited = 0;
    int run = 0;
    logic [10:0] bits;
    while (tx == 1 && waited < 4000) begin
      @(negedge clk); waited++;
    end
    chk(tx == 0, "R5", "ack start seen", tx, 0);
    chk(locked == 1, "R2", "locked at ack", locked, 1);
    chk(div == d, "R2", "divisor", div, d);
    while (tx == 0 && run < 5000) begin
      run++; @(negedge clk);
    end
    chk(run == d, "R5", "start bit length", run, d);
    bits[0] = 0;
    repeat (d / 2) @(negedge clk);
    bits[1] = tx;
    for (int k = 2; k < 11; k++) begin
      repeat (d) @(negedge clk);
      bits[k] = tx;
    end
    chk(bits[8:1] == 8'h79, "R5", "ack byte", bits[8:1], 8'h79);
    chk(bits[9] == 1, "R5", "parity bit", bits[9], 1);
    chk(bits[10] == 1, "R5", "stop bit", bits[10], 1);
    chk(busy == 1, "R6", "busy in stop bit", busy, 1);
    repeat (d / 2 + 3) @(negedge clk);
    chk(busy == 0, "R6", "busy after ack", busy, 0);
    chk(tx == 1, "R8", "tx idle after ack", tx, 1);
  endtask

  task automatic expect_no_lock(input string req);
    repeat (10) @(negedge clk);
    chk(locked == 0, req, "no lock", locked, 0);
    chk(busy == 0, req, "idle after discard", busy, 0);
    chk(tx == 1, "R8", "tx idle after discard", tx, 1);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int seed_dummy;
    int lows;
    seed_dummy = $urandom(32'd20240611);
    do_reset();
    // R1 reset state
    chk(locked == 0, "R1", "locked", locked, 0);
    chk(div == 0, "R1", "div", div, 0);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(tx == 1, "R1", "tx", tx, 1);

    // R3: below window, then rearm and lock
    send_sync(MIN_C - 1, 1);
    expect_no_lock("R3");
    send_sync(90, 1);
    check_ack(exp_div(90));

    // R3 boundary: exactly MIN accepted
    do_reset();
    send_sync(MIN_C, 1);
    check_ack(exp_div(MIN_C));

    // R4: line held low beyond window
    do_reset();
    rx = 0; repeat (MAX_C + 100) @(negedge clk);
    chk(locked == 0, "R4", "held-low no lock", locked, 0);
    chk(busy == 0, "R4", "held-low busy", busy, 0);
    rx = 1; repeat (20) @(negedge clk);
    // R4: one past MAX rejected, then MAX accepted
    send_sync(MAX_C + 1, 1);
    expect_no_lock("R4");
    send_sync(MAX_C, 1);
    check_ack(exp_div(MAX_C));

    // R2 rounding corners
    do_reset(); send_sync(9 * 7 + 4, 1); check_ack(exp_div(9 * 7 + 4));
    do_reset(); send_sync(9 * 7 + 5, 1); check_ack(exp_div(9 * 7 + 5));

    // R2 random rates
    for (int i = 0; i < 10; i++) begin
      int b = 4 + int'($urandom % 147);
      int t = 9 * b + int'($urandom % 9);
      do_reset();
      send_sync(t, 1);
      check_ack(exp_div(t));
    end

    // R7: activity during and after the ack is ignored
    do_reset();
    send_sync(9 * 12, 1);
    fork
      check_ack(12);
      begin
        repeat (30) @(negedge clk);
        repeat (4) begin
          rx = 0; repeat (5) @(negedge clk);
          rx = 1; repeat (5) @(negedge clk);
        end
      end
    join
    send_sync(9 * 30, 0);
    lows = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (tx == 0) lows++;
    end
    chk(lows == 0, "R7", "no second ack", lows, 0);
    chk(div == 12, "R7", "divisor held", div, 12);
    chk(locked == 1, "R7", "lock held", locked, 1);
    chk(busy == 0, "R7", "no busy after relock attempt", busy, 0);

    summary();
    $finish;
  end
endmodule